// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block sits between a free-running oscillator input and the clocked logic of a small microcontroller core. It halves the oscillator rate with a toggling phase register to make the internal clock rate, so the duty cycle of the raw input plays no part. The block then issues a one-cycle clock enable pulse on every internal clock to five consumers: the CPU, the timer, the serial interface with its bus watchdog timer, the interrupt logic, and the shared A/D and PWM group. Each consumer stays on the oscillator clock and qualifies its registers with its enable.

A two-bit power-control register chooses between normal running, idle and power-down. Idle halts the CPU and the A/D-PWM group while the timer, serial and interrupt enables keep pulsing. An enabled interrupt ends idle. Power-down stops the divider, withdraws the oscillator run request, and silences every enable. Only a hardware reset ends power-down. A status output tells the analog side when its reference voltage has had time to settle after reset or after leaving idle.

Top module: `lpcc_top`

## Requirements
- R1: While not powered down, the internal clock tick is high on every second oscillator cycle, so no clock enable output is high in two consecutive oscillator cycles.
- R2: While rst_n is low, all five enables are low, pcon_rdata reads 00 and osc_en is high. After rst_n rises, the first oscillator edge starts a tick cycle.
- R3: A write (pcon_we high; pcon_wdata bit 0 = idle, bit 1 = power-down) is taken on the edge that ends a tick cycle in which the CPU is running. That tick still carries cpu_ce. The new mode governs the enables from the next tick on.
- R4: In idle, cpu_ce and anpwm_ce stay low while tmr_ce, ser_ce and irq_ce keep pulsing on every tick.
- R5: wake_irq high during a tick in idle clears the idle bit, and cpu_ce and anpwm_ce return on the next tick. wake_irq while running has no effect.
- R6: Register writes made while idle are ignored, and pcon_rdata keeps reading 01.
- R7: In power-down, osc_en is low, all enables are low and the tick divider holds its phase.
- R8: Power-down ignores wake_irq and register writes. Only rst_n ends it.
- R9: Writing both mode bits as 1 enters power-down, and pcon_rdata reads 10.
- R10: adc_ready is low during reset, idle and power-down. It rises only after SETTLE_TICKS further ticks have passed since reset release or since idle exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Raw oscillator clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| pcon_we | input | 1 | Power-control register write strobe |
| pcon_wdata | input | 2 | Write data: bit 1 power-down, bit 0 idle |
| wake_irq | input | 1 | An enabled interrupt is pending |
| pcon_rdata | output | 2 | Current mode bits, same layout as pcon_wdata |
| osc_en | output | 1 | Oscillator run request, low in power-down |
| cpu_ce | output | 1 | CPU clock enable |
| tmr_ce | output | 1 | Timer clock enable |
| ser_ce | output | 1 | Serial interface and its watchdog clock enable |
| irq_ce | output | 1 | Interrupt logic clock enable |
| anpwm_ce | output | 1 | A/D and PWM group clock enable |
| adc_ready | output | 1 | Reference settling interval has elapsed |

## Verification
The assertions assume that rst_n is low at time zero. They also assume that pcon_we, pcon_wdata and wake_irq change only away from the rising oscillator edge, so each mode change is tied to one known tick. The bench meets both assumptions. It starts in reset and drives every input on the falling edge of a tick cycle, then clears it on the next falling edge. Each step of the stimulus therefore covers exactly one internal clock.

// File: rtl/lpcc_pkg.sv
package lpcc_pkg;

   localparam int unsigned NUM_DOM = 5;

   typedef enum logic [2:0] {
      DOM_CPU = 3'd0,
      DOM_TMR = 3'd1,
      DOM_SER = 3'd2,
      DOM_IRQ = 3'd3,
      DOM_ANP = 3'd4
   } dom_e;

   // domains whose enable keeps pulsing during idle
   localparam logic [NUM_DOM-1:0] IDLE_KEEP = 5'b01110;

   typedef struct packed {
      logic pdown;
      logic idle;
   } pwr_ctl_t;

endpackage

// File: rtl/lpcc_div2.sv
module lpcc_div2 (
   input  logic osc_clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   logic phase_q;

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= 1'b0;
      else if (run)
         phase_q <= ~phase_q;
   end

   assign tick = phase_q;

   assert_div_toggle_R1: assert property (@(posedge osc_clk) disable iff (!rst_n)
      run |=> (phase_q != $past(phase_q)));

   assert_div_frozen_R7: assert property (@(posedge osc_clk) disable iff (!rst_n)
      !run |=> $stable(phase_q));

endmodule

// File: rtl/lpcc_mode.sv
module lpcc_mode
   import lpcc_pkg::*;
(
   input  logic     osc_clk,
   input  logic     rst_n,
   input  logic     tick,
   input  logic     wr_en,
   input  pwr_ctl_t wr_ctl,
   input  logic     wake,
   output pwr_ctl_t ctl_q
);

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (tick) begin
         if (ctl_q.pdown) begin
            ctl_q <= ctl_q;
         end else if (ctl_q.idle) begin
            if (wake)
               ctl_q.idle <= 1'b0;
         end else if (wr_en) begin
            if (wr_ctl.pdown) begin
               ctl_q.pdown <= 1'b1;
               ctl_q.idle  <= 1'b0;
            end else begin
               ctl_q.idle  <= wr_ctl.idle;
            end
         end
      end
   end

   assert_pd_sticky_R8: assert property (@(posedge osc_clk) disable iff (!rst_n)
      ctl_q.pdown |=> ctl_q.pdown);

   assert_pd_excl_R9: assert property (@(posedge osc_clk) disable iff (!rst_n)
      ctl_q.pdown |-> !ctl_q.idle);

   assert_wake_R5: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (ctl_q.idle && tick && wake) |=> !ctl_q.idle);

   assert_idle_wr_R6: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (ctl_q.idle && !wake) |=> ctl_q.idle);

endmodule

// File: rtl/lpcc_settle.sv
module lpcc_settle #(
   parameter int unsigned SETTLE_TICKS = 16
) (
   input  logic osc_clk,
   input  logic rst_n,
   input  logic tick,
   input  logic hold,
   output logic ready
);

   localparam int unsigned CW = (SETTLE_TICKS > 0) ? $clog2(SETTLE_TICKS + 1) : 1;
   localparam logic [CW-1:0] LOAD = CW'(SETTLE_TICKS);

   if (SETTLE_TICKS > 32'h00FF_FFFF) begin : g_chk
      $error("lpcc_settle: SETTLE_TICKS too large");
   end

   if (SETTLE_TICKS == 0) begin : g_none
      assign ready = rst_n & ~hold;
   end else begin : g_cnt
      logic [CW-1:0] cnt_q;
      always_ff @(posedge osc_clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= LOAD;
         else if (hold)
            cnt_q <= LOAD;
         else if (tick && (cnt_q != '0))
            cnt_q <= cnt_q - CW'(1);
      end
      assign ready = (cnt_q == '0) & ~hold;
   end

   assert_ready_hold_R10: assert property (@(posedge osc_clk) disable iff (!rst_n)
      hold |-> !ready);

   assert_ready_stay_R10: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (ready && !hold) |=> (ready || hold));

endmodule

// File: rtl/lpcc_top.sv
module lpcc_top
   import lpcc_pkg::*;
#(
   parameter int unsigned SETTLE_TICKS = 16
) (
   input  logic       osc_clk,
   input  logic       rst_n,
   input  logic       pcon_we,
   input  logic [1:0] pcon_wdata,
   input  logic       wake_irq,
   output logic [1:0] pcon_rdata,
   output logic       osc_en,
   output logic       cpu_ce,
   output logic       tmr_ce,
   output logic       ser_ce,
   output logic       irq_ce,
   output logic       anpwm_ce,
   output logic       adc_ready
);

   logic                tick;
   pwr_ctl_t            ctl;
   logic [NUM_DOM-1:0]  ce_vec;

   lpcc_div2 u_div (
      .osc_clk (osc_clk),
      .rst_n   (rst_n),
      .run     (~ctl.pdown),
      .tick    (tick)
   );

   lpcc_mode u_mode (
      .osc_clk (osc_clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wr_en   (pcon_we & cpu_ce),
      .wr_ctl  (pwr_ctl_t'(pcon_wdata)),
      .wake    (wake_irq),
      .ctl_q   (ctl)
   );

   lpcc_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
      .osc_clk (osc_clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .hold    (ctl.idle | ctl.pdown),
      .ready   (adc_ready)
   );

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      assign ce_vec[d] = tick & ~ctl.pdown & (~ctl.idle | IDLE_KEEP[d]);
   end

   assign cpu_ce     = ce_vec[DOM_CPU];
   assign tmr_ce     = ce_vec[DOM_TMR];
   assign ser_ce     = ce_vec[DOM_SER];
   assign irq_ce     = ce_vec[DOM_IRQ];
   assign anpwm_ce   = ce_vec[DOM_ANP];
   assign osc_en     = ~ctl.pdown;
   assign pcon_rdata = ctl;

   assert_idle_gate_R4: assert property (@(posedge osc_clk) disable iff (!rst_n)
      ctl.idle |-> (!cpu_ce && !anpwm_ce));

   assert_idle_keep_R4: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (ctl.idle && tick) |-> (tmr_ce && ser_ce && irq_ce));

   assert_pd_quiet_R7: assert property (@(posedge osc_clk) disable iff (!rst_n)
      ctl.pdown |-> (!osc_en && $countones(ce_vec) == 0));

   assert_ce_spacing_R1: assert property (@(posedge osc_clk) disable iff (!rst_n)
      tmr_ce |=> !tmr_ce);

endmodule

// File: tb/lpcc_top_tb_top.sv
module lpcc_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pcon_we = 1'b0;
   logic [1:0] pcon_wdata = 2'b00;
   logic       wake_irq = 1'b0;
   logic [1:0] pcon_rdata;
   logic       osc_en, cpu_ce, tmr_ce, ser_ce, irq_ce, anpwm_ce, adc_ready;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   lpcc_top #(.SETTLE_TICKS(SETTLE)) dut_i (
      .osc_clk    (clk),
      .rst_n      (rst_n),
      .pcon_we    (pcon_we),
      .pcon_wdata (pcon_wdata),
      .wake_irq   (wake_irq),
      .pcon_rdata (pcon_rdata),
      .osc_en     (osc_en),
      .cpu_ce     (cpu_ce),
      .tmr_ce     (tmr_ce),
      .ser_ce     (ser_ce),
      .irq_ce     (irq_ce),
      .anpwm_ce   (anpwm_ce),
      .adc_ready  (adc_ready)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // row: we, wdata[1:0], wake | cpu, tmr/ser/irq, anpwm, pcon[1:0], osc_en
   localparam int NV = 8;
   localparam logic [9:0] VEC [NV] = '{
      {1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1},  // run
      {1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 1'b1},  // enter idle
      {1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 1'b1},  // write in idle
      {1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1},  // wake
      {1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1},  // run
      {1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1},  // wake while running
      {1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0},  // power-down
      {1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0}   // wake in power-down
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // entered and left at the falling edge of a tick cycle
   task automatic do_tick(input logic we, input logic [1:0] wd, input logic wk);
      pcon_we = we; pcon_wdata = wd; wake_irq = wk;
      @(posedge clk); @(negedge clk);
      pcon_we = 1'b0; pcon_wdata = 2'b00; wake_irq = 1'b0;
      @(posedge clk); @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R2 enables in reset", {3'b0, cpu_ce, tmr_ce, ser_ce, irq_ce, anpwm_ce}, 8'h00);
      check("R2 pcon in reset", {6'b0, pcon_rdata}, 8'h00);
      check("R2 osc_en in reset", {7'b0, osc_en}, 8'h01);
      check("R10 adc_ready in reset", {7'b0, adc_ready}, 8'h00);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R2 first tick after reset", {7'b0, cpu_ce}, 8'h01);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int ones;
      logic prev;
      do_reset();

      // vector walk: R3 R4 R5 R6 R7 R8
      for (int i = 0; i < NV; i++) begin
         logic [9:0] v;
         v = VEC[i];
         do_tick(v[9], v[8:7], v[6]);
         check($sformatf("R3/R4/R5/R6/R7/R8 row %0d cpu", i), {7'b0, cpu_ce}, {7'b0, v[5]});
         check($sformatf("R4/R7 row %0d periph", i), {5'b0, tmr_ce, ser_ce, irq_ce}, {5'b0, {3{v[4]}}});
         check($sformatf("R4/R7 row %0d anpwm", i), {7'b0, anpwm_ce}, {7'b0, v[3]});
         check($sformatf("R6/R8/R9 row %0d pcon", i), {6'b0, pcon_rdata}, {6'b0, v[2:1]});
         check($sformatf("R7 row %0d osc_en", i), {7'b0, osc_en}, {7'b0, v[0]});
      end

      // R7: divider frozen, nothing pulses for several cycles
      ones = 0;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         ones += int'(cpu_ce) + int'(tmr_ce) + int'(irq_ce);
      end
      check("R7 no enable in power-down", 8'(ones), 8'h00);

      // R8: reset ends power-down
      do_reset();
      check("R8 pcon after reset", {6'b0, pcon_rdata}, 8'h00);

      // R1: enable on every second cycle
      ones = 0; prev = 1'b0;
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         if (tmr_ce) ones++;
         if (tmr_ce && prev) ones += 100;
         prev = tmr_ce;
      end
      check("R1 tick count over 20 cycles", 8'(ones), 8'd10);

      // R10: settle after reset
      do_reset();
      for (int k = 0; k < SETTLE - 1; k++) do_tick(1'b0, 2'b00, 1'b0);
      check("R10 not ready one tick early", {7'b0, adc_ready}, 8'h00);
      do_tick(1'b0, 2'b00, 1'b0);
      check("R10 ready after settle", {7'b0, adc_ready}, 8'h01);

      // R3: write tick still carries cpu_ce; mode on next tick
      check("R3 cpu_ce on write tick", {7'b0, cpu_ce}, 8'h01);
      pcon_we = 1'b1; pcon_wdata = 2'b01;
      @(posedge clk); @(negedge clk);
      pcon_we = 1'b0; pcon_wdata = 2'b00;
      @(posedge clk); @(negedge clk);
      check("R3 cpu stops next tick", {6'b0, cpu_ce, tmr_ce}, 8'h01);
      check("R10 not ready in idle", {7'b0, adc_ready}, 8'h00);

      // R10: settle after idle exit
      do_tick(1'b0, 2'b00, 1'b1);
      check("R5 cpu resumes after wake", {7'b0, cpu_ce}, 8'h01);
      for (int k = 0; k < SETTLE - 1; k++) do_tick(1'b0, 2'b00, 1'b0);
      check("R10 not ready early after idle", {7'b0, adc_ready}, 8'h00);
      do_tick(1'b0, 2'b00, 1'b0);
      check("R10 ready after idle settle", {7'b0, adc_ready}, 8'h01);

      // R9: both bits at once
      do_tick(1'b1, 2'b11, 1'b0);
      check("R9 power-down wins", {6'b0, pcon_rdata}, 8'h02);
      check("R9 osc_en low", {7'b0, osc_en}, 8'h00);
      check("R10 not ready in power-down", {7'b0, adc_ready}, 8'h00);

      do_reset();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule